// File: doc/BRIEF.md
# SPI Register-Access Slave for a Quad Wiper Bank

This block is an SPI mode-0 slave that gives a host read and write access to a small register bank for four digitally set wipers. Each transaction opens with a fixed identification byte. Next comes a byte that holds a 4-bit opcode and a 4-bit register address, and then one or more data bytes. The address pointer advances after every data byte, so a host can stream several registers in one chip-select window.

Addresses 0 to 3 are shared by two sets of registers: the live wiper positions and their stored power-up values. A volatile-select bit in the control register picks which set an access reaches. A write to a stored value also loads the live wiper and raises a one-cycle request to an external non-volatile write engine. While that engine reports busy, every write is dropped, but reads still work. Addresses 4 to 6 hold general-purpose stored bytes. The serial output is open-drain, so the block only ever pulls the line low. All SPI pins are oversampled by the system clock.

Top module: `spi_pot_regs`

## Requirements
- R1: Data is sampled on a rising SCK edge and shifted out on a falling SCK edge, MSB first. This happens only while chip select is low and after the block has seen chip select fall. If chip select is already low when reset ends, nothing is decoded until chip select rises and falls again.
- R2: The first byte of a transaction must be 0x50. Any other value makes the block ignore the rest of that transaction: no register changes, and the output is not driven until chip select goes high.
- R3: In the second byte, bits 7:4 are the opcode and bits 3:0 are the start address. Opcode 1011 is a read and 1100 is a write. Any other opcode is ignored in the same way as a bad first byte.
- R4: The control register is at address 8. It reads as {vol, run, busy, 5'b0}, so vol is bit 7, run is bit 6 and busy is bit 5. After reset vol is 0 and run is 1, and run drives `run_en`. A write to address 8 changes only vol and run.
- R5: At addresses 0 to 3 with vol=1, reads and writes reach only the live wiper register. No non-volatile request is raised.
- R6: At addresses 0 to 3 with vol=0, a write updates both the stored value and the live wiper. It also raises `nv_wr_req` for one cycle, with the address and data. A read returns the stored value and leaves the wiper unchanged.
- R7: Addresses 4 to 6 are general-purpose stored registers. Each write to them raises `nv_wr_req`.
- R8: After each data byte the pointer increments, and it wraps from 6 to 0. This applies to both reads and writes.
- R9: While `nv_busy` is 1, writes to any address are ignored. A read of address 8 shows the busy bit set.
- R10: The output only ever pulls low. It does so only for 0 bits during the data phase of a valid read, and it is released whenever chip select is high.
- R11: Addresses 7 and 9 to 15 read as 0x00 and ignore writes.
- R12: If chip select goes high in the middle of a byte, the bit count and the transaction state are cleared. The next transaction then decodes normally.
- R13: After reset, every wiper and every stored wiper value is 0x40, the general-purpose registers are 0x00 and the output is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Active-low reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_sdi | input | 1 | Serial data from host |
| sdo_pull_low | output | 1 | Open-drain control: 1 pulls the data line low |
| nv_busy | input | 1 | Non-volatile write engine busy |
| nv_wr_req | output | 1 | One-cycle request to store a byte |
| nv_wr_addr | output | 4 | Address of the byte to store |
| nv_wr_data | output | 8 | Byte to store |
| wiper_o | output | 32 | Four live wiper positions, wiper 0 in bits 7:0 |
| run_en | output | 1 | Control run bit (0 requests shutdown) |

## Verification
Every register in the bank updates on the first clock edge that sees the rising SCK that ends a data byte. The next output bit is registered on the first clock edge that sees SCK low. The bench changes inputs only on falling clock edges and holds each SCK level for two clocks. It samples the released-or-pulled data line at the end of each low phase, one full clock after the output bit settles. It compares the wipers, `run_en` and the count of store requests three clocks after chip select rises. By then every write from the transaction has been in place for several cycles.

// File: rtl/spi_pot_regs.sv
module spi_pot_regs #(
  parameter int NUM_POT = 4,
  parameter int GP_NUM = 3,
  parameter int DW = 8,
  parameter int AW = 4,
  parameter int CTRL_ADDR = 8,
  parameter logic [7:0] ID_BYTE = 8'h50,
  parameter logic [3:0] OP_RD = 4'hB,
  parameter logic [3:0] OP_WR = 4'hC,
  parameter logic [7:0] POS_INIT = 8'h40
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  spi_csn,
  input  logic                  spi_sck,
  input  logic                  spi_sdi,
  output logic                  sdo_pull_low,
  input  logic                  nv_busy,
  output logic                  nv_wr_req,
  output logic [AW-1:0]         nv_wr_addr,
  output logic [DW-1:0]         nv_wr_data,
  output logic [NUM_POT*DW-1:0] wiper_o,
  output logic                  run_en
);
  localparam int CW = $clog2(DW);
  localparam int LAST_ADDR = NUM_POT + GP_NUM - 1;

  logic csn_q, sck_q, sel, bad, is_rd, sdo_bit, vol, run;
  logic [1:0] phase;
  logic [CW-1:0] bit_cnt;
  logic [DW-2:0] sh;
  logic [AW-1:0] ptr;
  logic [DW-1:0] wr_q [NUM_POT];
  logic [DW-1:0] ivr_q [NUM_POT];
  logic [DW-1:0] gp_q [GP_NUM];
  logic [DW-1:0] rd_byte;

  wire sck_rise = sel & spi_sck & ~sck_q;
  wire sck_fall = sel & ~spi_sck & sck_q;
  wire [DW-1:0] rx_byte = {sh, spi_sdi};
  wire byte_done = sck_rise && (bit_cnt == CW'(DW - 1));
  wire wr_ok = byte_done && phase == 2'd2 && !is_rd && !bad && !nv_busy;

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NUM_POT; i++)
      if (ptr == AW'(i)) rd_byte = vol ? wr_q[i] : ivr_q[i];
    for (int i = 0; i < GP_NUM; i++)
      if (ptr == AW'(NUM_POT + i)) rd_byte = gp_q[i];
    if (ptr == AW'(CTRL_ADDR)) rd_byte = {vol, run, nv_busy, {(DW-3){1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_q <= 1'b0; sck_q <= 1'b0; sel <= 1'b0; bad <= 1'b0; is_rd <= 1'b0;
      sdo_bit <= 1'b1; phase <= '0; bit_cnt <= '0; sh <= '0; ptr <= '0;
    end else begin
      csn_q <= spi_csn;
      sck_q <= spi_sck;
      if (spi_csn) begin
        sel <= 1'b0; bad <= 1'b0; is_rd <= 1'b0; sdo_bit <= 1'b1;
        phase <= '0; bit_cnt <= '0;
      end else begin
        if (csn_q) sel <= 1'b1;
        if (sck_rise) begin
          sh <= rx_byte[DW-2:0];
          bit_cnt <= bit_cnt + 1'b1;
          if (byte_done) begin
            case (phase)
              2'd0: begin
                if (rx_byte != ID_BYTE) bad <= 1'b1;
                phase <= 2'd1;
              end
              2'd1: begin
                if (rx_byte[DW-1 -: 4] != OP_RD && rx_byte[DW-1 -: 4] != OP_WR) bad <= 1'b1;
                is_rd <= (rx_byte[DW-1 -: 4] == OP_RD);
                ptr <= rx_byte[AW-1:0];
                phase <= 2'd2;
              end
              default: ptr <= (ptr == AW'(LAST_ADDR)) ? '0 : ptr + 1'b1;
            endcase
          end
        end
        if (sck_fall) sdo_bit <= rd_byte[CW'(DW - 1) - bit_cnt];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_POT; i++) begin
        wr_q[i] <= POS_INIT;
        ivr_q[i] <= POS_INIT;
      end
      for (int i = 0; i < GP_NUM; i++) gp_q[i] <= '0;
      vol <= 1'b0; run <= 1'b1;
      nv_wr_req <= 1'b0; nv_wr_addr <= '0; nv_wr_data <= '0;
    end else begin
      nv_wr_req <= 1'b0;
      if (wr_ok) begin
        for (int i = 0; i < NUM_POT; i++)
          if (ptr == AW'(i)) begin
            wr_q[i] <= rx_byte;
            if (!vol) begin
              ivr_q[i] <= rx_byte;
              nv_wr_req <= 1'b1; nv_wr_addr <= ptr; nv_wr_data <= rx_byte;
            end
          end
        for (int i = 0; i < GP_NUM; i++)
          if (ptr == AW'(NUM_POT + i)) begin
            gp_q[i] <= rx_byte;
            nv_wr_req <= 1'b1; nv_wr_addr <= ptr; nv_wr_data <= rx_byte;
          end
        if (ptr == AW'(CTRL_ADDR)) begin
          vol <= rx_byte[DW-1];
          run <= rx_byte[DW-2];
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_POT; g++) begin : g_wiper
    assign wiper_o[g*DW +: DW] = wr_q[g];
  end
  assign run_en = run;
  assign sdo_pull_low = ~spi_csn & sel & (phase == 2'd2) & is_rd & ~bad & ~sdo_bit;

  a_r9_busy_blocks_writes: assert property (@(posedge clk) disable iff (!rst_n)
    nv_busy |=> $stable(wiper_o) && $stable(run_en));
  a_r12_cs_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    spi_csn |=> (bit_cnt == '0) && (phase == 2'd0));
  a_r6_req_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    nv_wr_req |=> !nv_wr_req);
  a_r2_bad_id_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bad && !spi_csn) |=> $stable(wiper_o) && $stable(run_en));
  a_r1_unselected_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(wiper_o) && !nv_wr_req);
endmodule

// File: tb/test_spi_pot_regs.sv
module test_spi_pot_regs;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, spi_csn, spi_sck, spi_sdi, nv_busy;
  logic sdo_pull_low, nv_wr_req, run_en;
  logic [3:0] nv_wr_addr;
  logic [7:0] nv_wr_data;
  logic [31:0] wiper_o;

  spi_pot_regs i_spi_pot_regs (
    .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sck(spi_sck), .spi_sdi(spi_sdi),
    .sdo_pull_low(sdo_pull_low), .nv_busy(nv_busy), .nv_wr_req(nv_wr_req),
    .nv_wr_addr(nv_wr_addr), .nv_wr_data(nv_wr_data), .wiper_o(wiper_o), .run_en(run_en)
  );

  int n_chk = 0, n_fail = 0, nv_cnt = 0;
  logic [3:0] nv_la;
  logic [7:0] nv_ld;
  logic done = 1'b0;

  always @(posedge clk) if (nv_wr_req) begin
    nv_cnt++; nv_la = nv_wr_addr; nv_ld = nv_wr_data;
  end

  logic [7:0] m_wr [4];
  logic [7:0] m_ivr [4];
  logic [7:0] m_gp [3];
  logic m_vol, m_run;
  int m_nv;
  logic [7:0] tx [4];
  logic [7:0] rx [4];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read(input int a, input logic busy);
    if (a < 4) return m_vol ? m_wr[a] : m_ivr[a];
    if (a <= 6) return m_gp[a-4];
    if (a == 8) return {m_vol, m_run, busy, 5'b0};
    return 8'h00;
  endfunction

  task automatic m_write(input int a, input logic [7:0] d, input logic busy);
    if (busy) return;
    if (a < 4) begin
      m_wr[a] = d;
      if (!m_vol) begin m_ivr[a] = d; m_nv++; end
    end else if (a <= 6) begin
      m_gp[a-4] = d; m_nv++;
    end else if (a == 8) begin
      m_vol = d[7]; m_run = d[6];
    end
  endtask

  task automatic sbit(input logic b, output logic r);
    spi_sck = 1'b0; spi_sdi = b;
    repeat (2) @(negedge clk);
    r = ~sdo_pull_low;
    spi_sck = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic sbyte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) sbit(b[i], r[i]);
  endtask

  task automatic txn(input logic [7:0] id, input logic [7:0] cmd, input int n, input logic busy);
    logic [7:0] dummy;
    nv_busy = busy; spi_csn = 1'b0;
    repeat (3) @(negedge clk);
    sbyte(id, dummy);
    sbyte(cmd, dummy);
    for (int k = 0; k < n; k++) sbyte(tx[k], rx[k]);
    spi_sck = 1'b0;
    repeat (2) @(negedge clk);
    spi_csn = 1'b1;
    repeat (3) @(negedge clk);
    nv_busy = 1'b0;
  endtask

  task automatic check_state(input string req);
    chk(req, wiper_o, {m_wr[3], m_wr[2], m_wr[1], m_wr[0]});
    chk(req, run_en, m_run);
    chk(req, nv_cnt, m_nv);
    chk(req, sdo_pull_low, 1'b0);
  endtask

  task automatic do_txn(input string req, input logic [7:0] id, input logic [7:0] cmd,
                        input int n, input logic busy);
    logic valid, rd;
    int p;
    txn(id, cmd, n, busy);
    valid = (id == 8'h50) && (cmd[7:4] == 4'hB || cmd[7:4] == 4'hC);
    rd = cmd[7:4] == 4'hB;
    p = cmd[3:0];
    for (int k = 0; k < n; k++) begin
      if (valid && rd) chk(req, rx[k], m_read(p, busy));
      else chk(req, rx[k], 8'hFF);
      if (valid && !rd) m_write(p, tx[k], busy);
      p = (p == 6) ? 0 : (p + 1) % 16;
    end
    check_state(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] dummy;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) begin m_wr[i] = 8'h40; m_ivr[i] = 8'h40; end
    for (int i = 0; i < 3; i++) m_gp[i] = 8'h00;
    m_vol = 1'b0; m_run = 1'b1; m_nv = 0;
    rst_n = 1'b0; spi_csn = 1'b0; spi_sck = 1'b0; spi_sdi = 1'b0; nv_busy = 1'b0;
    repeat (4) @(negedge clk);
    chk("R13 reset wipers", wiper_o, 32'h40404040);
    chk("R4 reset run", run_en, 1'b1);
    chk("R10 reset release", sdo_pull_low, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    sbyte(8'h50, dummy); sbyte(8'hC0, dummy); sbyte(8'h11, dummy);
    repeat (3) @(negedge clk);
    chk("R1 no falling CS", wiper_o, 32'h40404040);
    chk("R1 no request", nv_cnt, 0);
    spi_sck = 1'b0; spi_csn = 1'b1;
    repeat (3) @(negedge clk);

    tx[0] = 8'h00; do_txn("R4 read ctrl", 8'h50, 8'hB8, 1, 1'b0);
    tx[0] = 8'hDF; do_txn("R4 write ctrl", 8'h50, 8'hC8, 1, 1'b0);
    do_txn("R4 ctrl low bits", 8'h50, 8'hB8, 1, 1'b0);
    tx[0] = 8'h77; do_txn("R5 vol write", 8'h50, 8'hC2, 1, 1'b0);
    do_txn("R5 vol read", 8'h50, 8'hB2, 1, 1'b0);
    tx[0] = 8'h40; do_txn("R6 clear vol", 8'h50, 8'hC8, 1, 1'b0);
    tx[0] = 8'h5A; do_txn("R6 stored write", 8'h50, 8'hC1, 1, 1'b0);
    chk("R6 req addr", nv_la, 4'h1);
    chk("R6 req data", nv_ld, 8'h5A);
    do_txn("R6 stored read keeps wiper", 8'h50, 8'hB2, 1, 1'b0);
    tx[0] = 8'hA5; do_txn("R7 gp write", 8'h50, 8'hC5, 1, 1'b0);
    do_txn("R7 gp read", 8'h50, 8'hB5, 1, 1'b0);
    tx[0] = 8'h01; tx[1] = 8'h02; tx[2] = 8'h03; tx[3] = 8'h04;
    do_txn("R8 write wrap", 8'h50, 8'hC5, 4, 1'b0);
    do_txn("R8 read wrap", 8'h50, 8'hB6, 3, 1'b0);
    tx[0] = 8'hEE; do_txn("R11 write 7", 8'h50, 8'hC7, 1, 1'b0);
    tx[0] = 8'hEE; do_txn("R11 write 12", 8'h50, 8'hCC, 1, 1'b0);
    do_txn("R11 read 7", 8'h50, 8'hB7, 1, 1'b0);
    do_txn("R11 read 15", 8'h50, 8'hBF, 1, 1'b0);
    tx[0] = 8'h99; do_txn("R9 busy write", 8'h50, 8'hC0, 1, 1'b1);
    tx[0] = 8'h00; do_txn("R9 busy ctrl write", 8'h50, 8'hC8, 1, 1'b1);
    do_txn("R9 busy ctrl read", 8'h50, 8'hB8, 1, 1'b1);
    tx[0] = 8'h33; do_txn("R2 bad id write", 8'h51, 8'hC0, 1, 1'b0);
    do_txn("R2 bad id read", 8'h70, 8'hB1, 1, 1'b0);
    tx[0] = 8'h33; do_txn("R3 bad opcode", 8'h50, 8'hD0, 1, 1'b0);
    do_txn("R3 bad opcode read", 8'h50, 8'hA1, 1, 1'b0);
    spi_csn = 1'b0; repeat (3) @(negedge clk);
    for (int i = 0; i < 3; i++) sbit(1'b1, dummy[0]);
    spi_sck = 1'b0; repeat (2) @(negedge clk);
    spi_csn = 1'b1; repeat (3) @(negedge clk);
    tx[0] = 8'h2C; do_txn("R12 after partial byte", 8'h50, 8'hC3, 1, 1'b0);
    tx[0] = 8'h00; do_txn("R4 shutdown", 8'h50, 8'hC8, 1, 1'b0);
    chk("R4 run low", run_en, 1'b0);

    for (int t = 0; t < 300; t++) begin
      logic [7:0] id, cmd;
      logic [3:0] op, ad;
      int n;
      id = ($urandom % 8 == 0) ? 8'($urandom) : 8'h50;
      op = ($urandom % 6 == 0) ? 4'($urandom) : (($urandom % 2 == 0) ? 4'hB : 4'hC);
      ad = ($urandom % 4 == 0) ? 4'h8 : 4'($urandom);
      cmd = {op, ad};
      n = 1 + $urandom % 3;
      for (int k = 0; k < 4; k++) tx[k] = 8'($urandom);
      do_txn("R8 random", id, cmd, n, ($urandom % 5 == 0));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule